// File: doc/BRIEF.md
# Fixed Off-Time Current Chopper

This block limits the current in an H-bridge load with a fixed off-time scheme. An external comparator watches the sensed load current and raises a one-bit trip signal when the current crosses its threshold. Whenever the bridge starts a drive period, the block first ignores the trip for a blanking window, which masks the switching spike. After the window, a trip forces the bridge into slow decay for a fixed number of cycles. Slow decay means both low-side switches are on. When that time is over, the bridge goes back to whatever the logic inputs ask for.

The surrounding bridge logic tells the block whether the inputs currently request a driving state, and whether a protection fault has disabled the bridge. The block returns a force-brake request, which overrides the bridge decode into the low-side-on state. It also returns its state code. The blanking length and the off-time are parameters counted in clock cycles. A blanking length of zero removes the blanking state completely.

Top module: `offtime_chopper`

## Requirements
- R1: While reset is asserted and in the first cycle after it is released, `chop_state` is 0 (idle) and `force_brake` is 0.
- R2: While `bridge_drive` is low, the block stays idle (state 0) and `force_brake` stays 0, whatever `trip` does.
- R3: When `bridge_drive` rises with no fault, the state becomes 1 (blanking) at the next edge. It stays 1 for exactly BLANK_CYC cycles and then becomes 2 (driving).
- R4: A trip during blanking is ignored: the state still moves to 2 and does not go to 3.
- R5: A trip sampled while the state is 2 moves the state to 3 (off) at the next edge. `force_brake` is 1 for exactly OFF_CYC cycles while the state is 3, and 0 in every other state.
- R6: When the off-time ends with `bridge_drive` high, a new blanking window of BLANK_CYC cycles starts, followed by state 2.
- R7: A trip held high through the off-time does not re-trip at once. The block completes the new blanking window, spends exactly one cycle in state 2 and then enters state 3 again.
- R8: With `fault_off` high, the block is idle with `force_brake` 0 from the next edge on, from any state. It stays idle while the fault lasts.
- R9: `bridge_drive` going low during blanking or driving returns the block to idle at the next edge. During the off-time it does not shorten the off-time, and the block goes idle when the off-time ends.
- R10: With BLANK_CYC = 0, the block goes from idle straight to state 2, and straight back to state 2 after an off-time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bridge_drive | input | 1 | High when the logic inputs request a driving bridge state |
| trip | input | 1 | Current comparator output, high above the trip current |
| fault_off | input | 1 | High while a protection fault disables the bridge |
| force_brake | output | 1 | Request to force both low-side switches on |
| chop_state | output | 2 | 0 idle, 1 blanking, 2 driving, 3 off-time |

## Verification
The bench measures the length of each blanking window and each off-time cycle by cycle. An off-by-one counter load would show up as a window one cycle too long or too short. A trip is held across the end of blanking and across a whole off-time. A design that sampled the trip during blanking would brake early. A design that skipped re-blanking would re-enter the off-time with no driving cycle in between. Faults and a dropped drive request are applied inside blanking, driving and off-time. A block that ignored them, or that cut the off-time short on a drive drop, would show the wrong state or a wrong brake request at the next edge. A second instance with no blanking checks the variant that bypasses the blanking state.

// File: rtl/chop_pkg.sv
package chop_pkg;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_BLANK = 2'd1,
      ST_DRIVE = 2'd2,
      ST_OFF   = 2'd3
   } chop_st_t;

   // width able to hold (max(a,b) - 1), at least one bit
   function automatic int unsigned cnt_width(input int unsigned a, input int unsigned b);
      int unsigned m;
      m = (a > b) ? a : b;
      return (m < 2) ? 1 : $clog2(m);
   endfunction

endpackage

// File: rtl/chop_cnt.sv
module chop_cnt #(
   parameter int unsigned W = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   output logic         is_zero
);
   logic [W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (load)
         cnt_q <= load_val;
      else if (cnt_q != '0)
         cnt_q <= cnt_q - 1'b1;
   end

   assign is_zero = (cnt_q == '0);
endmodule

// File: rtl/chop_fsm.sv
module chop_fsm
   import chop_pkg::*;
#(
   parameter int unsigned BLANK_CYC = 4,
   parameter int unsigned OFF_CYC   = 10,
   parameter int unsigned W         = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         drive,
   input  logic         trip,
   input  logic         fault,
   input  logic         cnt_zero,
   output chop_st_t     st,
   output logic         ld,
   output logic [W-1:0] ld_val
);
   localparam int unsigned BL_M1 = (BLANK_CYC > 0) ? BLANK_CYC - 1 : 0;
   localparam logic [W-1:0] BLANK_LD = W'(BL_M1);
   localparam logic [W-1:0] OFF_LD   = W'(OFF_CYC - 1);

   chop_st_t entry_st;
   chop_st_t nxt;

   generate
      if (BLANK_CYC > 0) begin : g_blank
         assign entry_st = ST_BLANK;
      end else begin : g_noblank
         assign entry_st = ST_DRIVE;
      end
   endgenerate

   always_comb begin
      nxt    = st;
      ld     = 1'b0;
      ld_val = '0;
      unique case (st)
         ST_IDLE: begin
            if (drive && !fault) begin
               nxt    = entry_st;
               ld     = 1'b1;
               ld_val = BLANK_LD;
            end
         end
         ST_BLANK: begin
            if (fault || !drive)
               nxt = ST_IDLE;
            else if (cnt_zero)
               nxt = ST_DRIVE;
         end
         ST_DRIVE: begin
            if (fault || !drive)
               nxt = ST_IDLE;
            else if (trip) begin
               nxt    = ST_OFF;
               ld     = 1'b1;
               ld_val = OFF_LD;
            end
         end
         ST_OFF: begin
            if (fault)
               nxt = ST_IDLE;
            else if (cnt_zero) begin
               if (drive) begin
                  nxt    = entry_st;
                  ld     = 1'b1;
                  ld_val = BLANK_LD;
               end else begin
                  nxt = ST_IDLE;
               end
            end
         end
         default: nxt = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         st <= ST_IDLE;
      else
         st <= nxt;
   end
endmodule

// File: rtl/offtime_chopper.sv
module offtime_chopper
   import chop_pkg::*;
#(
   parameter int unsigned BLANK_CYC = 4,
   parameter int unsigned OFF_CYC   = 10
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       bridge_drive,
   input  logic       trip,
   input  logic       fault_off,
   output logic       force_brake,
   output logic [1:0] chop_state
);
   localparam int unsigned CNT_W = cnt_width(BLANK_CYC, OFF_CYC);

   generate
      if (OFF_CYC < 1) begin : g_bad_off
         $error("OFF_CYC must be at least 1");
      end
      if (CNT_W > 32) begin : g_bad_w
         $error("cycle counts too large");
      end
   endgenerate

   chop_st_t         st;
   logic             ld;
   logic [CNT_W-1:0] ld_val;
   logic             cnt_zero;

   chop_fsm #(
      .BLANK_CYC (BLANK_CYC),
      .OFF_CYC   (OFF_CYC),
      .W         (CNT_W)
   ) u_fsm (
      .clk      (clk),
      .rst_n    (rst_n),
      .drive    (bridge_drive),
      .trip     (trip),
      .fault    (fault_off),
      .cnt_zero (cnt_zero),
      .st       (st),
      .ld       (ld),
      .ld_val   (ld_val)
   );

   // one counter serves both windows; they never overlap
   chop_cnt #(
      .W (CNT_W)
   ) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (ld),
      .load_val (ld_val),
      .is_zero  (cnt_zero)
   );

   assign chop_state  = st;
   assign force_brake = (st == ST_OFF);
endmodule

// File: rtl/chop_chk.sv
module chop_chk
   import chop_pkg::*;
#(
   parameter int unsigned BLANK_CYC = 4,
   parameter int unsigned OFF_CYC   = 10
) (
   input logic       clk,
   input logic       rst_n,
   input logic       drive,
   input logic       trip,
   input logic       fault,
   input logic       fb,
   input logic [1:0] st
);
   int unsigned off_run;
   int unsigned blank_run;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         off_run   <= 0;
         blank_run <= 0;
      end else begin
         off_run   <= (st == ST_OFF)   ? off_run + 1   : 0;
         blank_run <= (st == ST_BLANK) ? blank_run + 1 : 0;
      end
   end

   // R2
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_IDLE && !drive) |=> (st == ST_IDLE));

   // R5
   brake_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(fb) |-> ($past(st) == ST_DRIVE && $past(trip)));

   // R5
   off_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(st) == ST_OFF && st != ST_OFF && !$past(fault)) |-> (off_run == OFF_CYC));

   // R3
   blank_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(st) == ST_BLANK && st == ST_DRIVE) |-> (blank_run == BLANK_CYC));

   // R4
   blank_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_BLANK && drive && !fault && trip) |=> (st != ST_OFF));

   // R8
   fault_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fault |=> (st == ST_IDLE && !fb));
endmodule

bind offtime_chopper chop_chk #(
   .BLANK_CYC (BLANK_CYC),
   .OFF_CYC   (OFF_CYC)
) u_chk (
   .clk   (clk),
   .rst_n (rst_n),
   .drive (bridge_drive),
   .trip  (trip),
   .fault (fault_off),
   .fb    (force_brake),
   .st    (chop_state)
);

// File: tb/offtime_chopper_bench.sv
module offtime_chopper_bench;
   localparam int CLK_P = 10;
   localparam int B  = 4;
   localparam int O  = 10;
   localparam int O2 = 3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic drive = 1'b0;
   logic trip = 1'b0;
   logic fault = 1'b0;
   logic fb, fb2;
   logic [1:0] st, st2;
   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #(CLK_P/2) clk = ~clk;

   offtime_chopper #(.BLANK_CYC(B), .OFF_CYC(O)) u_offtime_chopper (
      .clk(clk), .rst_n(rst_n), .bridge_drive(drive), .trip(trip),
      .fault_off(fault), .force_brake(fb), .chop_state(st));

   offtime_chopper #(.BLANK_CYC(0), .OFF_CYC(O2)) u_offtime_chopper_nb (
      .clk(clk), .rst_n(rst_n), .bridge_drive(drive), .trip(trip),
      .fault_off(fault), .force_brake(fb2), .chop_state(st2));

   task automatic chk(input string tag, input logic [1:0] sa, input logic fa,
                      input logic [1:0] se, input logic fe);
      checks++;
      if (sa !== se || fa !== fe) begin
         errors++;
         $display("FAIL %s: state=%0d brake=%0b expected state=%0d brake=%0b",
                  tag, sa, fa, se, fe);
      end
   endtask

   task automatic step();
      @(negedge clk);
   endtask

   task automatic t_reset();
      step(); step();
      chk("R1 in reset", st, fb, 2'd0, 1'b0);
      rst_n = 1'b1;
      step();
      chk("R1 after reset", st, fb, 2'd0, 1'b0);
   endtask

   task automatic t_idle_trip();
      trip = 1'b1;
      for (int i = 0; i < 4; i++) begin
         step();
         chk("R2 trip in idle", st, fb, 2'd0, 1'b0);
      end
      trip = 1'b0;
   endtask

   task automatic t_blank();
      drive = 1'b1;
      trip  = 1'b1;
      for (int i = 1; i <= B; i++) begin
         step();
         chk("R3 blanking", st, fb, 2'd1, 1'b0);
         if (i == B) trip = 1'b0;
      end
      step();
      chk("R3 drive after blank", st, fb, 2'd2, 1'b0);
      step();
      chk("R4 blank trip ignored", st, fb, 2'd2, 1'b0);
   endtask

   task automatic t_chop();
      trip = 1'b1;
      step();
      chk("R5 off entry", st, fb, 2'd3, 1'b1);
      trip = 1'b0;
      for (int i = 2; i <= O; i++) begin
         step();
         chk("R5 off hold", st, fb, 2'd3, 1'b1);
      end
      for (int i = 0; i < B; i++) begin
         step();
         chk("R6 reblank", st, fb, 2'd1, 1'b0);
      end
      step();
      chk("R6 drive again", st, fb, 2'd2, 1'b0);
   endtask

   task automatic t_held();
      trip = 1'b1;
      for (int i = 0; i < O; i++) begin
         step();
         chk("R7 off", st, fb, 2'd3, 1'b1);
      end
      for (int i = 0; i < B; i++) begin
         step();
         chk("R7 blank", st, fb, 2'd1, 1'b0);
      end
      step();
      chk("R7 one drive cycle", st, fb, 2'd2, 1'b0);
      step();
      chk("R7 second off", st, fb, 2'd3, 1'b1);
      trip = 1'b0;
      for (int i = 1; i < O; i++) step();
      for (int i = 0; i < B; i++) step();
      step();
      chk("R7 back to drive", st, fb, 2'd2, 1'b0);
   endtask

   task automatic t_drop();
      drive = 1'b0;
      step();
      chk("R9 drop in drive", st, fb, 2'd0, 1'b0);
      drive = 1'b1;
      for (int i = 0; i < B; i++) step();
      step();
      chk("R9 drive reached", st, fb, 2'd2, 1'b0);
      trip = 1'b1;
      step();
      trip  = 1'b0;
      drive = 1'b0;
      for (int i = 1; i < O; i++) begin
         step();
         chk("R9 off not shortened", st, fb, 2'd3, 1'b1);
      end
      step();
      chk("R9 idle after off", st, fb, 2'd0, 1'b0);
   endtask

   task automatic t_fault();
      drive = 1'b1;
      step();
      chk("R8 pre blank", st, fb, 2'd1, 1'b0);
      fault = 1'b1;
      step();
      chk("R8 fault in blank", st, fb, 2'd0, 1'b0);
      step();
      chk("R8 fault held", st, fb, 2'd0, 1'b0);
      fault = 1'b0;
      for (int i = 0; i < B; i++) step();
      step();
      chk("R8 drive after fault", st, fb, 2'd2, 1'b0);
      trip = 1'b1;
      step();
      trip  = 1'b0;
      fault = 1'b1;
      step();
      chk("R8 fault in off", st, fb, 2'd0, 1'b0);
      fault = 1'b0;
      drive = 1'b0;
      step();
      chk("R8 idle after fault", st, fb, 2'd0, 1'b0);
   endtask

   task automatic t_noblank();
      drive = 1'b1;
      step();
      chk("R10 direct drive", st2, fb2, 2'd2, 1'b0);
      trip = 1'b1;
      step();
      chk("R10 off", st2, fb2, 2'd3, 1'b1);
      trip = 1'b0;
      for (int i = 1; i < O2; i++) step();
      step();
      chk("R10 drive after off", st2, fb2, 2'd2, 1'b0);
      drive = 1'b0;
      step();
      chk("R10 idle", st2, fb2, 2'd0, 1'b0);
   endtask

   initial begin
      t_reset();
      t_idle_trip();
      t_blank();
      t_chop();
      t_held();
      t_drop();
      t_fault();
      t_noblank();
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      #(CLK_P * 100000);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: state=%0d brake=%0b expected run to end", st, fb);
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule